// File: doc/BRIEF.md
# Double-Precision Special-Value Fix-Up Unit

This unit repairs the result of a floating-point sequence when its input was a special value. One IEEE-754 double-precision operand is sorted into one of eight token classes. The token index then selects a 4-bit response code from a table word supplied with the operand. The response code decides the output. The output can keep the caller's current destination value, pass the operand through, return the operand quieted, or return one of a set of fixed constants. Typical uses are forcing a reciprocal of zero to infinity, or forcing a NaN input to the indefinite NaN.

An 8-bit fault-enable byte gives, for each token class, whether a zero-divide flag, an invalid flag, or both are raised. The unit acts as though every exception mask is set: it only reports the flags and never traps. A denormals-are-zero control can turn inputs with a zero exponent field into +0.0 before they are classified. The decode logic is fully combinational. One register stage holds the result and the two flags, so every output shows the inputs that were present at the previous rising clock edge.

Top module: `fpx_fixup_unit`

## Requirements
- R1: Outputs are registered. The result and both flags show the inputs of the previous rising edge. A synchronous active-low reset clears the result to 0 and both flags to 0 on the next edge.
- R2: When `daz_en` is 1 and bits 62:52 of `src_val` are all zero, the working value is +0.0 (all bits zero). Otherwise the working value equals `src_val`, so a denormal is classed as an ordinary negative or positive value.
- R3: The token index of the working value is decided as follows. Exponent all ones with mantissa nonzero gives 0 when bit 51 is 1 (quiet NaN) and 1 when bit 51 is 0 (signalling NaN). Bits 62:0 all zero gives 2 (either sign). The value 0x3FF0000000000000 gives 3. Exponent all ones with mantissa zero gives 4 when the sign is 1 and 5 when the sign is 0. Any other value gives 6 when negative and 7 when positive.
- R4: The response code is `tbl_word[4*j+3:4*j]`, where j is the token index. Bits 63:32 of `tbl_word` have no effect.
- R5: Code 0 returns `dest_old` unchanged. Code 1 returns the working value.
- R6: Code 2 returns the working value with bit 51 set, keeping its sign and all other bits. Code 3 returns 0xFFF8000000000000.
- R7: Code 4 returns 0xFFF0000000000000. Code 5 returns 0x7FF0000000000000. Code 6 returns 0xFFF0000000000000 when the working sign is 1 and 0x7FF0000000000000 when it is 0.
- R8: Codes 7 to 11 return, in order, 0x8000000000000000, 0x0000000000000000, 0xBFF0000000000000, 0x3FF0000000000000 and 0x3FE0000000000000.
- R9: Codes 12 to 15 return, in order, 0x4056800000000000, 0x3FF921FB54442D18, 0x7FEFFFFFFFFFFFFF and 0xFFEFFFFFFFFFFFFF.
- R10: `zero_div_q` is 1 only when token 2 meets `fault_en[0]` or token 3 meets `fault_en[2]`.
- R11: `invalid_q` is 1 only for these pairs: token 2 with `fault_en[1]`, token 3 with `fault_en[3]`, token 1 with `fault_en[4]`, token 4 with `fault_en[5]`, token 6 with `fault_en[6]`, or token 5 with `fault_en[7]`. Tokens 0 and 7 never raise it.
- R12: Both flags can be 1 together for a single token (token 2 with `fault_en[1:0]`=11, or token 3 with `fault_en[3:2]`=11). Enable bits that belong to other tokens have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| src_val | input | 64 | Double-precision operand to classify |
| tbl_word | input | 64 | Response table; the low 32 bits hold eight 4-bit codes |
| fault_en | input | 8 | Per-token fault enable bits |
| daz_en | input | 1 | Treat zero-exponent inputs as +0.0 |
| dest_old | input | 64 | Current destination value, returned by code 0 |
| result_q | output | 64 | Registered fixed-up value |
| zero_div_q | output | 1 | Registered zero-divide flag |
| invalid_q | output | 1 | Registered invalid flag |

## Verification
The properties compare each output with the inputs of the cycle before. They therefore assume the inputs are stable across each rising edge and that reset has been released for at least one edge. The bench meets this by changing every input just after an edge and holding it until the next one. The value properties fire only on uniform table words (every field 0, every field 1, or every field 2), so they are independent of the token class. The bench applies those patterns among its directed vectors, and its random vectors draw operands from a pool that reaches all eight token classes.

// File: rtl/fpx_pkg.sv
// Package fpx_pkg
// Shared encodings for the fix-up unit: format widths, token classes and
// the fixed constants that the response codes select.
// Assumes IEEE-754 binary64 layout: sign, 11-bit exponent, 52-bit mantissa.
package fpx_pkg;

    localparam int EXP_W   = 11;
    localparam int MAN_W   = 52;
    localparam int FP_W    = 1 + EXP_W + MAN_W;
    localparam int N_TOK   = 8;
    localparam int CODE_W  = 4;
    localparam int FIELD_W = N_TOK * CODE_W;
    localparam int QBIT    = MAN_W - 1;

    typedef enum logic [2:0] {
        TK_QNAN = 3'd0,
        TK_SNAN = 3'd1,
        TK_ZERO = 3'd2,
        TK_PONE = 3'd3,
        TK_NINF = 3'd4,
        TK_PINF = 3'd5,
        TK_NEG  = 3'd6,
        TK_POS  = 3'd7
    } tok_e;

    localparam logic [FP_W-1:0] K_PZERO  = 64'h0000000000000000;
    localparam logic [FP_W-1:0] K_NZERO  = 64'h8000000000000000;
    localparam logic [FP_W-1:0] K_PONE   = 64'h3FF0000000000000;
    localparam logic [FP_W-1:0] K_NONE   = 64'hBFF0000000000000;
    localparam logic [FP_W-1:0] K_HALF   = 64'h3FE0000000000000;
    localparam logic [FP_W-1:0] K_PINF   = 64'h7FF0000000000000;
    localparam logic [FP_W-1:0] K_NINF   = 64'hFFF0000000000000;
    localparam logic [FP_W-1:0] K_INDEF  = 64'hFFF8000000000000;
    localparam logic [FP_W-1:0] K_NINETY = 64'h4056800000000000;
    localparam logic [FP_W-1:0] K_HALFPI = 64'h3FF921FB54442D18;
    localparam logic [FP_W-1:0] K_PMAX   = 64'h7FEFFFFFFFFFFFFF;
    localparam logic [FP_W-1:0] K_NMAX   = 64'hFFEFFFFFFFFFFFFF;

endpackage

// File: rtl/fpx_classify.sv
// Module fpx_classify
// Applies the denormals-are-zero substitution, then sorts the working value
// into one of the eight token classes. Purely combinational.
// Assumes the token classes are mutually exclusive and checked in a fixed order.
module fpx_classify
    import fpx_pkg::*;
(
    input  logic [FP_W-1:0] src_val,
    input  logic            daz_en,
    output logic [FP_W-1:0] work_val,
    output tok_e            tok
);

    logic [EXP_W-1:0] exp_f;
    logic [MAN_W-1:0] man_f;
    logic             sgn_f;
    logic             exp_max;
    logic             exp_min;

    // Replace zero-exponent inputs with +0.0 when the control asks for it.
    always_comb begin
        if (daz_en && (src_val[FP_W-2 -: EXP_W] == '0))
            work_val = '0;
        else
            work_val = src_val;
    end

    assign sgn_f   = work_val[FP_W-1];
    assign exp_f   = work_val[FP_W-2 -: EXP_W];
    assign man_f   = work_val[MAN_W-1:0];
    assign exp_max = &exp_f;
    assign exp_min = ~|exp_f;

    // Pick the token class of the working value.
    always_comb begin
        if (exp_max && (man_f != '0))
            tok = man_f[QBIT] ? TK_QNAN : TK_SNAN;
        else if (exp_max)
            tok = sgn_f ? TK_NINF : TK_PINF;
        else if (exp_min && (man_f == '0))
            tok = TK_ZERO;
        else if (work_val == K_PONE)
            tok = TK_PONE;
        else
            tok = sgn_f ? TK_NEG : TK_POS;
    end

endmodule

// File: rtl/fpx_respond.sv
// Module fpx_respond
// Extracts the 4-bit response code for the current token from the table
// fields and turns it into the fixed-up value. Purely combinational.
// Assumes the table fields are packed with token 0 in the lowest nibble.
module fpx_respond
    import fpx_pkg::*;
(
    input  logic [FIELD_W-1:0] tbl_lo,
    input  tok_e               tok,
    input  logic [FP_W-1:0]    work_val,
    input  logic [FP_W-1:0]    dest_old,
    output logic [FP_W-1:0]    res_val
);

    logic [CODE_W-1:0] field [N_TOK];
    logic [CODE_W-1:0] code;

    // Split the table word into one response field per token.
    genvar g;
    generate
        for (g = 0; g < N_TOK; g++) begin : g_field
            assign field[g] = tbl_lo[g*CODE_W +: CODE_W];
        end
    endgenerate

    assign code = field[tok];

    // Map the selected code to the output value.
    always_comb begin
        case (code)
            4'h0: res_val = dest_old;
            4'h1: res_val = work_val;
            4'h2: res_val = work_val | (FP_W'(1) << QBIT);
            4'h3: res_val = K_INDEF;
            4'h4: res_val = K_NINF;
            4'h5: res_val = K_PINF;
            4'h6: res_val = work_val[FP_W-1] ? K_NINF : K_PINF;
            4'h7: res_val = K_NZERO;
            4'h8: res_val = K_PZERO;
            4'h9: res_val = K_NONE;
            4'hA: res_val = K_PONE;
            4'hB: res_val = K_HALF;
            4'hC: res_val = K_NINETY;
            4'hD: res_val = K_HALFPI;
            4'hE: res_val = K_PMAX;
            default: res_val = K_NMAX;
        endcase
    end

endmodule

// File: rtl/fpx_faults.sv
// Module fpx_faults
// Combines the token with the fault-enable byte to form the zero-divide and
// invalid flags. Purely combinational.
// Assumes one token at a time; a token may raise both flags.
module fpx_faults
    import fpx_pkg::*;
(
    input  tok_e       tok,
    input  logic [7:0] fault_en,
    output logic       zero_div,
    output logic       invalid
);

    logic [N_TOK-1:0] tok_hot;

    // One-hot decode of the token for the flag terms.
    genvar g;
    generate
        for (g = 0; g < N_TOK; g++) begin : g_hot
            assign tok_hot[g] = (tok == tok_e'(g));
        end
    endgenerate

    // Zero-divide terms: zero and exact +1.0.
    always_comb begin
        zero_div = (tok_hot[TK_ZERO] & fault_en[0])
                 | (tok_hot[TK_PONE] & fault_en[2]);
    end

    // Invalid terms: one enable bit per participating token.
    always_comb begin
        invalid = (tok_hot[TK_ZERO] & fault_en[1])
                | (tok_hot[TK_PONE] & fault_en[3])
                | (tok_hot[TK_SNAN] & fault_en[4])
                | (tok_hot[TK_NINF] & fault_en[5])
                | (tok_hot[TK_NEG]  & fault_en[6])
                | (tok_hot[TK_PINF] & fault_en[7]);
    end

endmodule

// File: rtl/fpx_fixup_unit.sv
// Module fpx_fixup_unit
// Top of the special-value fix-up unit: classification, response lookup and
// fault flags, followed by a single output register stage.
// Assumes inputs are stable around each rising edge; reset is synchronous,
// active low, and clears the outputs.
module fpx_fixup_unit
    import fpx_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [FP_W-1:0] src_val,
    input  logic [FP_W-1:0] tbl_word,
    input  logic [7:0]      fault_en,
    input  logic            daz_en,
    input  logic [FP_W-1:0] dest_old,
    output logic [FP_W-1:0] result_q,
    output logic            zero_div_q,
    output logic            invalid_q
);

    logic [FP_W-1:0] work_val;
    tok_e            tok;
    logic [FP_W-1:0] res_d;
    logic            zd_d;
    logic            iv_d;
    logic            unused_tbl_hi;

    assign unused_tbl_hi = ^tbl_word[FP_W-1:FIELD_W];

    fpx_classify u_cls (
        .src_val  (src_val),
        .daz_en   (daz_en),
        .work_val (work_val),
        .tok      (tok)
    );

    fpx_respond u_rsp (
        .tbl_lo   (tbl_word[FIELD_W-1:0]),
        .tok      (tok),
        .work_val (work_val),
        .dest_old (dest_old),
        .res_val  (res_d)
    );

    fpx_faults u_flt (
        .tok      (tok),
        .fault_en (fault_en),
        .zero_div (zd_d),
        .invalid  (iv_d)
    );

    // Output register stage with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q   <= '0;
            zero_div_q <= 1'b0;
            invalid_q  <= 1'b0;
        end else begin
            result_q   <= res_d;
            zero_div_q <= zd_d;
            invalid_q  <= iv_d;
        end
    end

endmodule

// File: rtl/fpx_fixup_chk.sv
// Module fpx_fixup_chk
// Temporal checks on the fix-up unit's ports, attached by bind below.
// Assumes inputs settle between edges and compares outputs to the inputs
// sampled one edge earlier.
module fpx_fixup_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [63:0] src_val,
    input logic [63:0] tbl_word,
    input logic [7:0]  fault_en,
    input logic        daz_en,
    input logic [63:0] dest_old,
    input logic [63:0] result_q,
    input logic        zero_div_q,
    input logic        invalid_q
);

    logic unused_chk;
    assign unused_chk = ^tbl_word[63:32];

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (result_q == 64'h0 && !zero_div_q && !invalid_q));

    assert_keep_dest_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(tbl_word[31:0]) == 32'h0) |-> result_q == $past(dest_old));

    assert_pass_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(tbl_word[31:0]) == 32'h11111111 && !$past(daz_en))
        |-> result_q == $past(src_val));

    assert_daz_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(tbl_word[31:0]) == 32'h11111111 && $past(daz_en)
         && $past(src_val[62:52]) == 11'h0) |-> result_q == 64'h0);

    assert_quiet_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(tbl_word[31:0]) == 32'h22222222 && !$past(daz_en))
        |-> (result_q[51] && result_q[63:52] == $past(src_val[63:52])
             && result_q[50:0] == $past(src_val[50:0])));

    assert_no_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(fault_en) == 8'h0) |-> (!zero_div_q && !invalid_q));

    assert_pinf_invalid_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(src_val) == 64'h7FF0000000000000 && $past(fault_en[7]))
        |-> (invalid_q && !zero_div_q));

    assert_zero_both_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(src_val[62:0]) == 63'h0 && $past(fault_en[1:0]) == 2'b11)
        |-> (zero_div_q && invalid_q));

endmodule

bind fpx_fixup_unit fpx_fixup_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_val    (src_val),
    .tbl_word   (tbl_word),
    .fault_en   (fault_en),
    .daz_en     (daz_en),
    .dest_old   (dest_old),
    .result_q   (result_q),
    .zero_div_q (zero_div_q),
    .invalid_q  (invalid_q)
);

// File: tb/sim_fpx_fixup_unit.sv
// Bench for fpx_fixup_unit: a behavioural reference predicts every output
// one edge after the inputs are applied and is compared on every clock.
module sim_fpx_fixup_unit;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src_val = '0;
    logic [63:0] tbl_word = '0;
    logic [7:0]  fault_en = '0;
    logic        daz_en = 1'b0;
    logic [63:0] dest_old = '0;
    logic [63:0] result_q;
    logic        zero_div_q;
    logic        invalid_q;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    fpx_fixup_unit u0 (
        .clk(clk), .rst_n(rst_n), .src_val(src_val), .tbl_word(tbl_word),
        .fault_en(fault_en), .daz_en(daz_en), .dest_old(dest_old),
        .result_q(result_q), .zero_div_q(zero_div_q), .invalid_q(invalid_q)
    );

    // Reference: token class of a working value, by the rules of R3.
    function automatic int ref_token(input logic [63:0] v);
        bit top_exp = (v[62:52] == 11'h7FF);
        if (top_exp && v[51:0] != 0) return v[51] ? 0 : 1;
        if (top_exp) return v[63] ? 4 : 5;
        if (v[62:0] == 0) return 2;
        if (v == 64'h3FF0000000000000) return 3;
        return v[63] ? 6 : 7;
    endfunction

    // Reference: value returned for a response code (R5 to R9).
    function automatic logic [63:0] ref_value(input int code, input logic [63:0] w,
                                              input logic [63:0] d);
        logic [63:0] consts [16];
        consts[4]  = 64'hFFF0000000000000; consts[5]  = 64'h7FF0000000000000;
        consts[7]  = 64'h8000000000000000; consts[8]  = 64'h0;
        consts[9]  = 64'hBFF0000000000000; consts[10] = 64'h3FF0000000000000;
        consts[11] = 64'h3FE0000000000000; consts[12] = 64'h4056800000000000;
        consts[13] = 64'h3FF921FB54442D18; consts[14] = 64'h7FEFFFFFFFFFFFFF;
        consts[15] = 64'hFFEFFFFFFFFFFFFF;
        consts[3]  = 64'hFFF8000000000000;
        if (code == 0) return d;
        if (code == 1) return w;
        if (code == 2) return {w[63:52], 1'b1, w[50:0]};
        if (code == 6) return w[63] ? consts[4] : consts[5];
        return consts[code];
    endfunction

    function automatic string code_tag(input int code);
        if (code <= 1)  return "R5";
        if (code <= 3)  return "R6";
        if (code <= 6)  return "R7";
        if (code <= 11) return "R8";
        return "R9";
    endfunction

    task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: result got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check1(input string tag, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: flag got %b expected %b", tag, act, exp);
        end
    endtask

    // Apply one vector, wait one edge, compare all outputs.
    task automatic run_vec(input logic [63:0] s, input logic [63:0] t, input logic [63:0] d,
                           input logic [7:0] f, input logic z, input string tag);
        logic [63:0] w;
        int          tk;
        int          code;
        logic        ezd;
        logic        eiv;
        string       vt;
        w    = (z && s[62:52] == 0) ? 64'h0 : s;
        tk   = ref_token(w);
        code = int'((t >> (4 * tk)) & 64'hF);
        ezd  = (tk == 2 && f[0]) || (tk == 3 && f[2]);
        eiv  = (tk == 2 && f[1]) || (tk == 3 && f[3]) || (tk == 1 && f[4]) ||
               (tk == 4 && f[5]) || (tk == 6 && f[6]) || (tk == 5 && f[7]);
        vt   = (tag == "") ? code_tag(code) : tag;
        src_val = s; tbl_word = t; dest_old = d; fault_en = f; daz_en = z;
        @(posedge clk); #1;
        check64(vt, result_q, ref_value(code, w, d));
        check1((tag == "R12") ? "R12" : "R10", zero_div_q, ezd);
        check1((tag == "R12") ? "R12" : "R11", invalid_q, eiv);
    endtask

    function automatic logic [63:0] pool(input int i, input logic [63:0] rnd);
        case (i % 14)
            0:  return 64'h7FF8000000000000;
            1:  return 64'h7FF0000000000001;
            2:  return 64'h0000000000000000;
            3:  return 64'h8000000000000000;
            4:  return 64'h3FF0000000000000;
            5:  return 64'hFFF0000000000000;
            6:  return 64'h7FF0000000000000;
            7:  return 64'hBFF0000000000000;
            8:  return 64'h000F000000000123;
            9:  return 64'h800F000000000123;
            10: return 64'hFFFC00000000ABCD;
            11: return 64'hFFF4000000000001;
            default: return rnd;
        endcase
    endfunction

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        localparam logic [63:0] TBL_ID = 64'h00000000FEDCBA98;
        localparam logic [63:0] DST    = 64'h123456789ABCDEF0;
        localparam logic [63:0] NEG25  = 64'hC004000000000000;

        // R1: reset clears outputs.
        src_val = 64'h3FF0000000000000; tbl_word = {16{4'hC}}; fault_en = 8'hFF;
        repeat (2) @(posedge clk);
        #1;
        check64("R1", result_q, 64'h0);
        check1("R1", zero_div_q, 1'b0);
        check1("R1", invalid_q, 1'b0);
        rst_n = 1'b1;

        // R3: each token class gets its own constant (code 8 + token).
        run_vec(64'h7FF8000000000000, TBL_ID, DST, 8'h00, 1'b0, "R3");
        run_vec(64'h7FF0000000000001, TBL_ID, DST, 8'h00, 1'b0, "R3");
        run_vec(64'h8000000000000000, TBL_ID, DST, 8'h00, 1'b0, "R3");
        run_vec(64'h3FF0000000000000, TBL_ID, DST, 8'h00, 1'b0, "R3");
        run_vec(64'hFFF0000000000000, TBL_ID, DST, 8'h00, 1'b0, "R3");
        run_vec(64'h7FF0000000000000, TBL_ID, DST, 8'h00, 1'b0, "R3");
        run_vec(NEG25,                TBL_ID, DST, 8'h00, 1'b0, "R3");
        run_vec(64'h3FF0000000000001, TBL_ID, DST, 8'h00, 1'b0, "R3");

        // R4: field position and ignored upper table half.
        run_vec(64'h7FF0000000000001, 64'h00000000000000A0, DST, 8'h00, 1'b0, "R4");
        run_vec(64'h7FF8000000000000, 64'h00000000000000A0, DST, 8'h00, 1'b0, "R4");
        run_vec(64'h3FF0000000000000, 64'hFFFFFFFF00000000, DST, 8'h00, 1'b0, "R4");

        // R2: denormal with and without the zero substitution.
        run_vec(64'h000F000000000123, TBL_ID, DST, 8'h00, 1'b1, "R2");
        run_vec(64'h000F000000000123, TBL_ID, DST, 8'h00, 1'b0, "R2");
        run_vec(64'h800F000000000123, {16{4'h1}}, DST, 8'h03, 1'b1, "R2");
        run_vec(64'h800F000000000123, {16{4'h1}}, DST, 8'h03, 1'b0, "R2");

        // R5 to R9: every code on a uniform table.
        for (int c = 0; c < 16; c++) begin
            run_vec(NEG25, {16{c[3:0]}}, DST, 8'h00, 1'b0, "");
            run_vec(64'h7FF0000000000000, {16{c[3:0]}}, DST, 8'h00, 1'b0, "");
        end
        run_vec(64'h7FF0000000000001, {16{4'h2}}, DST, 8'h00, 1'b0, "R6");

        // R10, R11, R12: flag pairings.
        for (int i = 0; i < 12; i++)
            run_vec(pool(i, 64'h0), TBL_ID, DST, 8'hFF, 1'b0, "");
        run_vec(64'h0000000000000000, TBL_ID, DST, 8'h03, 1'b0, "R12");
        run_vec(64'h3FF0000000000000, TBL_ID, DST, 8'h0C, 1'b0, "R12");
        run_vec(64'h3FF0000000000000, TBL_ID, DST, 8'hF3, 1'b0, "R12");
        run_vec(64'h7FF8000000000000, TBL_ID, DST, 8'hFF, 1'b0, "R11");

        // Mixed random vectors.
        for (int n = 0; n < 600; n++) begin
            logic [63:0] r;
            r = {$urandom, $urandom};
            run_vec(pool(int'($urandom % 14), r), {$urandom, $urandom},
                    {$urandom, $urandom}, 8'($urandom), 1'($urandom), "");
        end

        // R1: reset in the middle of a run.
        rst_n = 1'b0;
        @(posedge clk); #1;
        check64("R1", result_q, 64'h0);
        check1("R1", invalid_q, 1'b0);
        rst_n = 1'b1;
        run_vec(64'h0, {16{4'hD}}, DST, 8'h01, 1'b0, "R1");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule